// File: doc/BRIEF.md
# USB2 PHY Power-Up Sequencer

This block brings a two-port USB2 PHY out of power-down in a fixed, timed order, and takes it back down in reverse. A start request from one of the ports first turns on the shared reference clock. Once that clock has settled, the block releases the shared power-on reset. After a second settle time it issues a single configuration write that switches on the PHY's internal clock. It waits again, then releases the UTMI reset of the port that asked. A final settle time passes before `seq_done` goes high.

Every wait is a whole number of microseconds. A prescaler divides the system clock, whose frequency in MHz is a parameter, to produce the microsecond timebase. The configuration write uses a simple request and acknowledge pair. The request stays up until the register port takes it, so the write is never dropped. A stop request from the done state undoes the bring-up one step per cycle: UTMI reset first, then power-on reset, then the reference clock.

Top module: `usb2phy_pwrup_seq`

## Requirements
- R1: While reset is applied, and after it with no request, `ref_clk_en` is 0, `por_rst_n` is 0, all `utmi_rst_n` bits are 0, `cfg_wr_req` is 0 and `seq_done` is 0.
- R2: A start request sampled while idle raises `ref_clk_en` on that clock edge. `por_rst_n` stays 0 for exactly REF_US*CLK_MHZ further cycles.
- R3: After `por_rst_n` rises, exactly POR_US*CLK_MHZ cycles pass before `cfg_wr_req` rises. No `utmi_rst_n` bit is released before then.
- R4: The configuration write always targets port field 0 and register address 0x06, with data 0x04 (only bit 2 set, the PHY clock enable). This holds whichever port started the sequence.
- R5: `cfg_wr_req` stays 1 until a cycle in which `cfg_wr_ack` is 1, and it drops on the edge that samples the acknowledge.
- R6: Exactly PHYCLK_US*CLK_MHZ cycles after the acknowledging edge, the `utmi_rst_n` bit of the requesting port (bit index = `start_port`) goes to 1. The other port's bit stays 0, and at most one bit is 1 at any time.
- R7: `seq_done` rises exactly UTMI_US*CLK_MHZ cycles after the port's UTMI reset is released, and it stays high while the UTMI reset is released.
- R8: A start request is ignored unless the block is idle. A stop request is ignored unless `seq_done` is 1. Neither one changes the step timing or the selected port.
- R9: A stop request sampled in the done state drops `seq_done` and all `utmi_rst_n` bits on that edge. `por_rst_n` falls one cycle later, and `ref_clk_en` falls one cycle after that.
- R10: `por_rst_n` is never 1 while `ref_clk_en` is 0, and no `utmi_rst_n` bit is 1 while `por_rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Begin bring-up (honoured only when idle) |
| start_port | input | 1 | Index of the requesting port, latched with start |
| stop_req | input | 1 | Begin teardown (honoured only when done) |
| ref_clk_en | output | 1 | Enable for the shared PHY reference clock |
| por_rst_n | output | 1 | Shared PHY power-on reset, active low |
| utmi_rst_n | output | 2 | Per-port UTMI reset, active low |
| cfg_wr_req | output | 1 | Configuration write request |
| cfg_wr_ack | input | 1 | Register port accepts the write |
| cfg_port | output | 3 | Port field of the configuration write |
| cfg_addr | output | 8 | Register address of the configuration write |
| cfg_data | output | 8 | Data of the configuration write |
| seq_done | output | 1 | Bring-up complete, PHY port usable |

## Verification
The bring-up runs from a table of four patterns. Each pattern pairs a requesting port (0 or 1) with an acknowledge delay of 0, 3 or 7 cycles. The port choice separates a correct per-port UTMI release from a hard-wired one, and it also shows whether the configuration write wrongly follows the requesting port. The varying acknowledge delay separates a write that is held until accepted from one that times out or drops early. It also shows whether the PHY-clock wait is timed from the acknowledge rather than from the request. Directed runs then cover several cases:
- start and stop pulses injected during a wait, which must not disturb the step count or the selected port;
- a start pulse while done;
- stop and acknowledge pulses while idle;
- the three-cycle teardown order.

// File: rtl/usb2phy_seq_pkg.sv
package usb2phy_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_REF_SETTLE = 4'd1,
    ST_POR_SETTLE = 4'd2,
    ST_CFG_WRITE  = 4'd3,
    ST_PCLK_SETTLE= 4'd4,
    ST_UTMI_SETTLE= 4'd5,
    ST_READY      = 4'd6,
    ST_DN_UTMI    = 4'd7,
    ST_DN_POR     = 4'd8
  } seq_state_e;

  // Clock cycles spent in a settle step of the given length.
  function automatic int unsigned settle_cycles(input int unsigned us,
                                                input int unsigned clk_mhz);
    return us * clk_mhz;
  endfunction

  // Width able to hold the largest of four microsecond limits.
  function automatic int unsigned us_width(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // Power-on reset is released in these states.
  function automatic logic por_free(input seq_state_e s);
    return (s == ST_POR_SETTLE) || (s == ST_CFG_WRITE) || (s == ST_PCLK_SETTLE) ||
           (s == ST_UTMI_SETTLE) || (s == ST_READY) || (s == ST_DN_UTMI);
  endfunction

  // UTMI reset of the selected port is released in these states.
  function automatic logic utmi_free(input seq_state_e s);
    return (s == ST_UTMI_SETTLE) || (s == ST_READY);
  endfunction

endpackage

// File: rtl/usb2phy_us_timer.sv
module usb2phy_us_timer #(
  parameter int unsigned CLK_MHZ = 200,
  parameter int unsigned US_W    = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [US_W-1:0] limit_us,
  output logic            expired
);
  localparam int unsigned PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_MHZ - 1);

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q;
  logic             us_tick;

  assign us_tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (clr) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (us_tick) begin
      pre_q <= '0;
      us_q  <= us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // Fires on the last cycle of the limit_us-th microsecond since clr.
  assign expired = us_tick && (limit_us != '0) && (us_q == limit_us - US_W'(1));

endmodule

// File: rtl/usb2phy_port_rst.sv
module usb2phy_port_rst #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned PORT_W = 1
) (
  input  logic              release_i,
  input  logic [PORT_W-1:0] sel,
  output logic [NPORTS-1:0] rst_n
);
  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    assign rst_n[i] = release_i && (sel == PORT_W'(i));
  end
endmodule

// File: rtl/usb2phy_pwrup_seq.sv
module usb2phy_pwrup_seq
  import usb2phy_seq_pkg::*;
#(
  parameter int unsigned NPORTS     = 2,
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned REF_US     = 100,
  parameter int unsigned POR_US     = 300,
  parameter int unsigned PCLK_US    = 2000,
  parameter int unsigned UTMI_US    = 2000,
  parameter logic [7:0]  CFG_ADDR   = 8'h06,
  parameter int unsigned CLK_EN_BIT = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      start_req,
  input  logic [((NPORTS > 1) ? $clog2(NPORTS) : 1)-1:0] start_port,
  input  logic                                      stop_req,
  output logic                                      ref_clk_en,
  output logic                                      por_rst_n,
  output logic [NPORTS-1:0]                         utmi_rst_n,
  output logic                                      cfg_wr_req,
  input  logic                                      cfg_wr_ack,
  output logic [2:0]                                cfg_port,
  output logic [7:0]                                cfg_addr,
  output logic [7:0]                                cfg_data,
  output logic                                      seq_done
);
  localparam int unsigned PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int unsigned US_W   = us_width(REF_US, POR_US, PCLK_US, UTMI_US);

  seq_state_e        state_q, state_d;
  logic [PORT_W-1:0] port_q;
  logic [US_W-1:0]   limit_us;
  logic              step_expired;

  // Named internal events.
  logic launch_accept, teardown_accept, step_change, write_taken;

  assign launch_accept   = (state_q == ST_IDLE)  && start_req;
  assign teardown_accept = (state_q == ST_READY) && stop_req;
  assign write_taken     = (state_q == ST_CFG_WRITE) && cfg_wr_ack;
  assign step_change     = (state_d != state_q);

  always_comb begin
    unique case (state_q)
      ST_REF_SETTLE:  limit_us = US_W'(REF_US);
      ST_POR_SETTLE:  limit_us = US_W'(POR_US);
      ST_PCLK_SETTLE: limit_us = US_W'(PCLK_US);
      ST_UTMI_SETTLE: limit_us = US_W'(UTMI_US);
      default:        limit_us = '0;
    endcase
  end

  usb2phy_us_timer #(.CLK_MHZ(CLK_MHZ), .US_W(US_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (step_change),
    .limit_us (limit_us),
    .expired  (step_expired)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:        if (launch_accept)   state_d = ST_REF_SETTLE;
      ST_REF_SETTLE:  if (step_expired)    state_d = ST_POR_SETTLE;
      ST_POR_SETTLE:  if (step_expired)    state_d = ST_CFG_WRITE;
      ST_CFG_WRITE:   if (write_taken)     state_d = ST_PCLK_SETTLE;
      ST_PCLK_SETTLE: if (step_expired)    state_d = ST_UTMI_SETTLE;
      ST_UTMI_SETTLE: if (step_expired)    state_d = ST_READY;
      ST_READY:       if (teardown_accept) state_d = ST_DN_UTMI;
      ST_DN_UTMI:                          state_d = ST_DN_POR;
      ST_DN_POR:                           state_d = ST_IDLE;
      default:                             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      port_q  <= '0;
    end else begin
      state_q <= state_d;
      if (launch_accept) port_q <= start_port;
    end
  end

  assign ref_clk_en = (state_q != ST_IDLE);
  assign por_rst_n  = por_free(state_q);
  assign cfg_wr_req = (state_q == ST_CFG_WRITE);
  assign seq_done   = (state_q == ST_READY);
  assign cfg_port   = 3'd0;
  assign cfg_addr   = CFG_ADDR;
  assign cfg_data   = 8'(1) << CLK_EN_BIT;

  usb2phy_port_rst #(.NPORTS(NPORTS), .PORT_W(PORT_W)) port_rst_i (
    .release_i (utmi_free(state_q)),
    .sel       (port_q),
    .rst_n     (utmi_rst_n)
  );

  // Assertions
  p_por_needs_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    por_rst_n |-> ref_clk_en);
  p_utmi_needs_por_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|utmi_rst_n) |-> por_rst_n);
  p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(utmi_rst_n));
  p_write_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_req && !cfg_wr_ack) |=> cfg_wr_req);
  p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (|utmi_rst_n));
  p_utmi_before_por_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_rst_n) |-> (utmi_rst_n == '0));
  p_por_before_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_clk_en) |-> !por_rst_n);
  p_stop_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !seq_done && por_rst_n && !$fell(seq_done)) |=> !($fell(por_rst_n)));

endmodule

// File: tb/usb2phy_pwrup_seq_tb.sv
`timescale 1ns/100ps
module usb2phy_pwrup_seq_tb_top;
  localparam int MHZ   = 4;
  localparam int REF   = 2;
  localparam int POR   = 3;
  localparam int PCLK  = 5;
  localparam int UTMI  = 4;
  localparam int WD    = 150000;

  // Vector: bit 7 = requesting port, bits 6:0 = acknowledge delay in cycles.
  localparam int NVEC = 4;
  localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'h80, 8'h03, 8'h87};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, stop_req = 1'b0, cfg_wr_ack = 1'b0;
  logic [0:0] start_port = 1'b0;
  logic ref_clk_en, por_rst_n, cfg_wr_req, seq_done;
  logic [1:0] utmi_rst_n;
  logic [2:0] cfg_port;
  logic [7:0] cfg_addr, cfg_data;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  usb2phy_pwrup_seq #(
    .NPORTS(2), .CLK_MHZ(MHZ), .REF_US(REF), .POR_US(POR),
    .PCLK_US(PCLK), .UTMI_US(UTMI), .CFG_ADDR(8'h06), .CLK_EN_BIT(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_port(start_port),
    .stop_req(stop_req), .ref_clk_en(ref_clk_en), .por_rst_n(por_rst_n),
    .utmi_rst_n(utmi_rst_n), .cfg_wr_req(cfg_wr_req), .cfg_wr_ack(cfg_wr_ack),
    .cfg_port(cfg_port), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .seq_done(seq_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bringup(input int p, input int d, input bit inject);
    int cnt;
    start_req = 1'b1;
    start_port = 1'(p);
    step();
    start_req = 1'b0;
    chk(ref_clk_en && !por_rst_n, "R2 clk on, por held", {ref_clk_en, por_rst_n}, 2);
    cnt = 0;
    while (!por_rst_n && cnt < 2000) begin
      if (inject && cnt == 2) begin
        start_req = 1'b1; start_port = 1'(!p); stop_req = 1'b1;
      end else begin
        start_req = 1'b0; stop_req = 1'b0;
      end
      step();
      cnt++;
    end
    start_req = 1'b0; stop_req = 1'b0;
    chk(cnt == REF * MHZ, inject ? "R8 ref wait with injected requests" : "R2 ref wait", cnt, REF * MHZ);
    chk(!cfg_wr_req && utmi_rst_n == 2'b00, "R3 nothing early", {cfg_wr_req, utmi_rst_n}, 0);
    cnt = 0;
    while (!cfg_wr_req && cnt < 2000) begin step(); cnt++; end
    chk(cnt == POR * MHZ, "R3 por wait", cnt, POR * MHZ);
    chk(cfg_port == 3'd0, "R4 port field", cfg_port, 0);
    chk(cfg_addr == 8'h06, "R4 address", cfg_addr, 6);
    chk(cfg_data == 8'h04, "R4 data", cfg_data, 4);
    for (int k = 0; k < d; k++) begin
      step();
      chk(cfg_wr_req == 1'b1, "R5 request held", cfg_wr_req, 1);
    end
    cfg_wr_ack = 1'b1;
    step();
    cfg_wr_ack = 1'b0;
    chk(cfg_wr_req == 1'b0, "R5 request dropped", cfg_wr_req, 0);
    cnt = 0;
    while (!utmi_rst_n[p] && cnt < 2000) begin step(); cnt++; end
    chk(cnt == PCLK * MHZ, "R6 phy clock wait", cnt, PCLK * MHZ);
    chk(utmi_rst_n[1-p] == 1'b0, "R6 other port held", utmi_rst_n[1-p], 0);
    chk(seq_done == 1'b0, "R7 not done yet", seq_done, 0);
    cnt = 0;
    while (!seq_done && cnt < 2000) begin step(); cnt++; end
    chk(cnt == UTMI * MHZ, "R7 utmi wait", cnt, UTMI * MHZ);
    chk(utmi_rst_n[p] == 1'b1, "R7 port stays released", utmi_rst_n[p], 1);
  endtask

  task automatic teardown();
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    chk(utmi_rst_n == 2'b00 && !seq_done && por_rst_n && ref_clk_en,
        "R9 utmi first", {utmi_rst_n, seq_done, por_rst_n, ref_clk_en}, 3);
    step();
    chk(!por_rst_n && ref_clk_en, "R9 por second", {por_rst_n, ref_clk_en}, 1);
    step();
    chk(!ref_clk_en, "R9 clock last", ref_clk_en, 0);
  endtask

  initial begin
    repeat (2) step();
    chk(!ref_clk_en && !por_rst_n && utmi_rst_n == 2'b00 && !cfg_wr_req && !seq_done,
        "R1 in reset", {ref_clk_en, por_rst_n, utmi_rst_n, cfg_wr_req, seq_done}, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk(!ref_clk_en && !por_rst_n && utmi_rst_n == 2'b00 && !cfg_wr_req && !seq_done,
        "R1 idle after reset", {ref_clk_en, por_rst_n, utmi_rst_n, cfg_wr_req, seq_done}, 0);

    for (int v = 0; v < NVEC; v++) begin
      bringup(int'(VEC[v][7]), int'(VEC[v][6:0]), 1'b0);
      teardown();
      step();
    end

    // R8: requests injected mid-sequence, then start while done.
    bringup(0, 1, 1'b1);
    start_req = 1'b1; start_port = 1'b1;
    step();
    start_req = 1'b0;
    step();
    chk(seq_done && utmi_rst_n == 2'b01, "R8 start while done ignored", {seq_done, utmi_rst_n}, 5);
    teardown();

    // R8: stop and acknowledge while idle.
    stop_req = 1'b1; cfg_wr_ack = 1'b1;
    step();
    stop_req = 1'b0; cfg_wr_ack = 1'b0;
    step();
    chk(!ref_clk_en && !por_rst_n && !cfg_wr_req, "R8 stop while idle ignored",
        {ref_clk_en, por_rst_n, cfg_wr_req}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule